// File: doc/BRIEF.md
# Masked Vector Element Sequencer

This block executes one vector arithmetic instruction at a time against an external vector register file. It processes one element per clock. An instruction carries a 3-bit opcode, a masking control bit, a destination and two source register indices, and a 32-bit scalar operand. For element operations the sequencer steps an element index upward from zero. At each index it presents both source addresses to the register file read ports and takes the read data back in the same cycle. One clock later it drives the computed result on the write port.

The sequencer holds two pieces of architectural state. The active-length register limits every element operation. The per-element mask register is filled by a compare, or loaded one 32-bit word at a time from the scalar operand. When the masking bit of an instruction is set, only elements whose mask bit is 1 are written back. Masked-off elements still take their clock slot. `busy` is high while elements are being processed, and `done` pulses once for each accepted instruction. Both registers are brought out so that the scalar side can read them.

Top module: `vec_elem_seq`

## Requirements
- R1: After reset the active length is 64, the mask is all zeros, and `busy` and `done` are low.
- R2: Opcode 5 loads the active length from the scalar operand and saturates values above 64 to 64. It completes with `done` one cycle after it is accepted.
- R3: Opcode 6 loads the scalar operand into mask bits [32w+31:32w], where w is bit 0 of the destination index. The other mask word is left unchanged. It completes in one cycle.
- R4: Opcode 0 writes dest[i] = srcA[i] + srcB[i] modulo 2^32 for every i below the active length.
- R5: Opcode 1 writes dest[i] = scalar + srcB[i] modulo 2^32.
- R6: Opcodes 2 (vector times vector) and 3 (scalar times srcB) write the low 32 bits of the product.
- R7: Opcode 4 sets mask bit i to 1 when srcA[i] equals srcB[i] and to 0 otherwise, for i below the active length. Mask bits at or above the length are unchanged, and no register element is written. The masking bit has no effect on this opcode.
- R8: With the masking bit set, an element operation writes element i only where mask bit i is 1. Without it, every element below the length is written. No element at or above the length is ever written.
- R9: An element operation with a nonzero length L processes one element per clock. `busy` is high from the cycle after acceptance until the last element. `done` pulses L+1 cycles after the accepting clock edge, in the same cycle that the last write is presented.
- R10: An element operation issued while the active length is zero completes with `done` one cycle after acceptance and changes no register element and no mask bit.
- R11: A `start` raised while `busy` is high is ignored, and the instruction it carries has no effect.
- R12: Opcode 7 does nothing and completes in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Issue request, accepted when not busy |
| op | input | 3 | Opcode |
| masked | input | 1 | Apply the mask to write-back |
| vd | input | 3 | Destination register index (bit 0 also selects the mask word for opcode 6) |
| vs1 | input | 3 | First source register index |
| vs2 | input | 3 | Second source register index |
| scalar | input | 32 | Scalar operand |
| busy | output | 1 | Element operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_a_reg | output | 3 | Read port A register index |
| rd_b_reg | output | 3 | Read port B register index |
| rd_idx | output | 6 | Element index for both read ports |
| rd_a_data | input | 32 | Read port A data, same cycle |
| rd_b_data | input | 32 | Read port B data, same cycle |
| wr_en | output | 1 | Write strobe |
| wr_reg | output | 3 | Write register index |
| wr_idx | output | 6 | Write element index |
| wr_data | output | 32 | Write data |
| vlen | output | 7 | Active length register |
| mask | output | 64 | Mask register |

## Verification
The bench exercises the following corner cases, and each one exposes a particular kind of fault.
- Length writes above 64 and equal to zero. A design without saturation would run past the register end, and a mishandled zero length would hang or write garbage.
- Partial-length compares. A design that touched bits beyond the length would corrupt stale mask state.
- Masked operations over mixed mask patterns. A design that ignored the mask would overwrite protected elements.
- Operations in which the destination also serves as a source. These expose an off-by-one between the read and write indices.
- A second `start` raised during a long operation. A design without the busy gate would change the length in the middle of an operation.

Every instruction is also timed against the L+1 latency, so that an extra or missing pipeline stage is caught.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

    typedef enum logic [2:0] {
        OP_ADDVV  = 3'd0,
        OP_ADDSV  = 3'd1,
        OP_MULVV  = 3'd2,
        OP_MULSV  = 3'd3,
        OP_CMPEQ  = 3'd4,
        OP_SETLEN = 3'd5,
        OP_SETMSK = 3'd6,
        OP_NOP    = 3'd7
    } vop_e;

    // op walks the element index
    function automatic logic is_elem(vop_e op);
        return (op <= OP_CMPEQ);
    endfunction

    // op writes a vector register
    function automatic logic writes_vreg(vop_e op);
        return (op <= OP_MULSV);
    endfunction

    function automatic logic uses_scalar(vop_e op);
        return (op == OP_ADDSV) || (op == OP_MULSV);
    endfunction

    function automatic logic is_mul(vop_e op);
        return (op == OP_MULVV) || (op == OP_MULSV);
    endfunction

endpackage

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
    import vseq_pkg::*;
#(
    parameter  int NREG  = 8,
    parameter  int MAXVL = 64,
    parameter  int DW    = 32,
    localparam int RW    = $clog2(NREG),
    localparam int IW    = $clog2(MAXVL),
    localparam int LW    = $clog2(MAXVL + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  vop_e          op_in,
    input  logic          masked_in,
    input  logic [RW-1:0] vd_in,
    input  logic [RW-1:0] vs1_in,
    input  logic [RW-1:0] vs2_in,
    input  logic [DW-1:0] scalar_in,
    input  logic [LW-1:0] vlen,
    output logic          accept,
    output logic          busy,
    output logic          done,
    output logic          last,
    output vop_e          cur_op,
    output logic          cur_msk,
    output logic [RW-1:0] cur_vd,
    output logic [RW-1:0] cur_vs1,
    output logic [RW-1:0] cur_vs2,
    output logic [DW-1:0] cur_scalar,
    output logic [IW-1:0] idx
);

    assign accept = start && !busy;
    assign last   = busy && ((LW'(idx) + LW'(1)) == vlen);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            done       <= 1'b0;
            idx        <= '0;
            cur_op     <= OP_NOP;
            cur_msk    <= 1'b0;
            cur_vd     <= '0;
            cur_vs1    <= '0;
            cur_vs2    <= '0;
            cur_scalar <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                cur_op     <= op_in;
                cur_msk    <= masked_in;
                cur_vd     <= vd_in;
                cur_vs1    <= vs1_in;
                cur_vs2    <= vs2_in;
                cur_scalar <= scalar_in;
                idx        <= '0;
                if (is_elem(op_in) && (vlen != '0)) begin
                    busy <= 1'b1;
                end else begin
                    done <= 1'b1;
                end
            end else if (busy) begin
                if (last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    idx  <= '0;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    // R9: index advances by one each clock until the last element
    a_r9_idx_step: assert property (@(posedge clk) disable iff (rst)
        (busy && !last) |=> (busy && (idx == $past(idx) + 1'b1)));

    // R9: done never overlaps element processing
    a_r9_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R11: latched instruction holds while busy
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(cur_op) && $stable(cur_vd) && $stable(cur_msk)));

endmodule

// File: rtl/vseq_state.sv
module vseq_state #(
    parameter  int MAXVL = 64,
    parameter  int DW    = 32,
    localparam int IW    = $clog2(MAXVL),
    localparam int LW    = $clog2(MAXVL + 1),
    localparam int NWORD = (MAXVL + DW - 1) / DW,
    localparam int WSW   = (NWORD > 1) ? $clog2(NWORD) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_len,
    input  logic [DW-1:0]    len_val,
    input  logic             ld_msk,
    input  logic [WSW-1:0]   msk_sel,
    input  logic [DW-1:0]    msk_val,
    input  logic             cmp_we,
    input  logic [IW-1:0]    cmp_idx,
    input  logic             cmp_eq,
    output logic [LW-1:0]    vlen,
    output logic [MAXVL-1:0] mask
);

    logic [LW-1:0] len_sat;
    assign len_sat = (len_val > DW'(MAXVL)) ? LW'(MAXVL) : LW'(len_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            vlen <= LW'(MAXVL);
            mask <= '0;
        end else begin
            if (ld_len) begin
                vlen <= len_sat;
            end
            for (int w = 0; w < NWORD; w++) begin
                if (ld_msk && (msk_sel == WSW'(w))) begin
                    for (int b = 0; b < DW; b++) begin
                        if (w * DW + b < MAXVL) begin
                            mask[w*DW+b] <= msk_val[b];
                        end
                    end
                end
            end
            if (cmp_we) begin
                mask[cmp_idx] <= cmp_eq;
            end
        end
    end

    // R2: length never exceeds the register size
    a_r2_len_bound: assert property (@(posedge clk) disable iff (rst)
        vlen <= LW'(MAXVL));

    // R7: a compare step touches at most one mask bit
    a_r7_cmp_one_bit: assert property (@(posedge clk) disable iff (rst)
        cmp_we |=> ($countones(mask ^ $past(mask)) <= 1));

    // R11: length does not move without a load
    a_r11_len_stable: assert property (@(posedge clk) disable iff (rst)
        !ld_len |=> $stable(vlen));

endmodule

// File: rtl/vseq_wb.sv
module vseq_wb
    import vseq_pkg::*;
#(
    parameter  int NREG  = 8,
    parameter  int MAXVL = 64,
    parameter  int DW    = 32,
    localparam int RW    = $clog2(NREG),
    localparam int IW    = $clog2(MAXVL)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  vop_e          op,
    input  logic          msk_en,
    input  logic          mask_bit,
    input  logic [DW-1:0] scalar,
    input  logic [DW-1:0] a_data,
    input  logic [DW-1:0] b_data,
    input  logic [RW-1:0] vd,
    input  logic [IW-1:0] idx,
    output logic          wr_en,
    output logic [RW-1:0] wr_reg,
    output logic [IW-1:0] wr_idx,
    output logic [DW-1:0] wr_data
);

    logic [DW-1:0] opa;
    logic [DW-1:0] result;

    always_comb begin
        opa    = uses_scalar(op) ? scalar : a_data;
        result = is_mul(op) ? (opa * b_data) : (opa + b_data);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en   <= 1'b0;
            wr_reg  <= '0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en   <= run && writes_vreg(op) && (!msk_en || mask_bit);
            wr_reg  <= vd;
            wr_idx  <= idx;
            wr_data <= result;
        end
    end

    // R8: a masked-off element produces no write
    a_r8_mask_off: assert property (@(posedge clk) disable iff (rst)
        (run && msk_en && !mask_bit) |=> !wr_en);

    // R7: a compare never writes a register
    a_r7_cmp_no_write: assert property (@(posedge clk) disable iff (rst)
        (run && (op == OP_CMPEQ)) |=> !wr_en);

endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq
    import vseq_pkg::*;
#(
    parameter  int NREG  = 8,
    parameter  int MAXVL = 64,
    parameter  int DW    = 32,
    localparam int RW    = $clog2(NREG),
    localparam int IW    = $clog2(MAXVL),
    localparam int LW    = $clog2(MAXVL + 1),
    localparam int NWORD = (MAXVL + DW - 1) / DW,
    localparam int WSW   = (NWORD > 1) ? $clog2(NWORD) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [2:0]       op,
    input  logic             masked,
    input  logic [RW-1:0]    vd,
    input  logic [RW-1:0]    vs1,
    input  logic [RW-1:0]    vs2,
    input  logic [DW-1:0]    scalar,
    output logic             busy,
    output logic             done,
    output logic [RW-1:0]    rd_a_reg,
    output logic [RW-1:0]    rd_b_reg,
    output logic [IW-1:0]    rd_idx,
    input  logic [DW-1:0]    rd_a_data,
    input  logic [DW-1:0]    rd_b_data,
    output logic             wr_en,
    output logic [RW-1:0]    wr_reg,
    output logic [IW-1:0]    wr_idx,
    output logic [DW-1:0]    wr_data,
    output logic [LW-1:0]    vlen,
    output logic [MAXVL-1:0] mask
);

    vop_e          op_e;
    vop_e          cur_op;
    logic          accept;
    logic          last;
    logic          cur_msk;
    logic [RW-1:0] cur_vd;
    logic [RW-1:0] cur_vs1;
    logic [RW-1:0] cur_vs2;
    logic [DW-1:0] cur_scalar;
    logic [IW-1:0] idx;

    assign op_e = vop_e'(op);

    vseq_ctrl #(.NREG(NREG), .MAXVL(MAXVL), .DW(DW)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .op_in(op_e),
        .masked_in(masked), .vd_in(vd), .vs1_in(vs1), .vs2_in(vs2),
        .scalar_in(scalar), .vlen(vlen), .accept(accept), .busy(busy),
        .done(done), .last(last), .cur_op(cur_op), .cur_msk(cur_msk),
        .cur_vd(cur_vd), .cur_vs1(cur_vs1), .cur_vs2(cur_vs2),
        .cur_scalar(cur_scalar), .idx(idx)
    );

    vseq_state #(.MAXVL(MAXVL), .DW(DW)) u_state (
        .clk(clk), .rst(rst),
        .ld_len(accept && (op_e == OP_SETLEN)), .len_val(scalar),
        .ld_msk(accept && (op_e == OP_SETMSK)), .msk_sel(vd[WSW-1:0]),
        .msk_val(scalar),
        .cmp_we(busy && (cur_op == OP_CMPEQ)), .cmp_idx(idx),
        .cmp_eq(rd_a_data == rd_b_data),
        .vlen(vlen), .mask(mask)
    );

    vseq_wb #(.NREG(NREG), .MAXVL(MAXVL), .DW(DW)) u_wb (
        .clk(clk), .rst(rst), .run(busy), .op(cur_op), .msk_en(cur_msk),
        .mask_bit(mask[idx]), .scalar(cur_scalar), .a_data(rd_a_data),
        .b_data(rd_b_data), .vd(cur_vd), .idx(idx), .wr_en(wr_en),
        .wr_reg(wr_reg), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    assign rd_a_reg = cur_vs1;
    assign rd_b_reg = cur_vs2;
    assign rd_idx   = idx;

    // R8: writes stay below the active length
    a_r8_wr_in_len: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (LW'(wr_idx) < vlen));

    // R10: nothing is written while idle
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> !wr_en);

endmodule

// File: tb/tb_vec_elem_seq.sv
`timescale 1ns/1ps
module tb_vec_elem_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd7;
    logic        masked = 1'b0;
    logic [2:0]  vd = '0, vs1 = '0, vs2 = '0;
    logic [31:0] scalar = '0;
    logic        busy, done, wr_en;
    logic [2:0]  rd_a_reg, rd_b_reg, wr_reg;
    logic [5:0]  rd_idx, wr_idx;
    logic [31:0] rd_a_data, rd_b_data, wr_data;
    logic [6:0]  vlen;
    logic [63:0] mask;

    logic [31:0] rf     [8][64];
    logic [31:0] exp_rf [8][64];
    logic [63:0] exp_mask;
    int          exp_vl;
    int          checks = 0;
    int          errors = 0;

    always #4 clk = ~clk;

    vec_elem_seq dut (
        .clk(clk), .rst(rst), .start(start), .op(op), .masked(masked),
        .vd(vd), .vs1(vs1), .vs2(vs2), .scalar(scalar), .busy(busy),
        .done(done), .rd_a_reg(rd_a_reg), .rd_b_reg(rd_b_reg),
        .rd_idx(rd_idx), .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_reg(wr_reg), .wr_idx(wr_idx), .wr_data(wr_data),
        .vlen(vlen), .mask(mask)
    );

    assign rd_a_data = rf[rd_a_reg][rd_idx];
    assign rd_b_data = rf[rd_b_reg][rd_idx];

    always @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < 8; r++)
                for (int i = 0; i < 64; i++)
                    rf[r][i] <= exp_rf[r][i];
        end else if (wr_en) begin
            rf[wr_reg][wr_idx] <= wr_data;
        end
    end

    task automatic check(input logic ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic string req_of(input int o);
        case (o)
            0: return "R4";
            1: return "R5";
            2, 3: return "R6";
            4: return "R7";
            5: return "R2";
            6: return "R3";
            default: return "R12";
        endcase
    endfunction

    // reference model of one instruction
    task automatic model(input int o, input logic m, input int d, input int a,
                         input int b, input logic [31:0] sc);
        logic [31:0] x;
        case (o)
            5: exp_vl = (sc > 64) ? 64 : int'(sc);
            6: exp_mask[(d % 2)*32 +: 32] = sc;
            4: for (int i = 0; i < exp_vl; i++)
                   exp_mask[i] = (exp_rf[a][i] == exp_rf[b][i]);
            0, 1, 2, 3: for (int i = 0; i < exp_vl; i++) begin
                   x = (o == 1 || o == 3) ? sc : exp_rf[a][i];
                   if (!m || exp_mask[i])
                       exp_rf[d][i] = (o >= 2) ? x * exp_rf[b][i] : x + exp_rf[b][i];
               end
            default: ;
        endcase
    endtask

    task automatic issue(input int o, input logic m, input int d, input int a,
                         input int b, input logic [31:0] sc, input string req,
                         input logic intrude);
        int cyc;
        int lat;
        lat = (o <= 4 && exp_vl > 0) ? exp_vl + 1 : 1;
        @(negedge clk);
        start = 1'b1; op = 3'(o); masked = m; vd = 3'(d); vs1 = 3'(a);
        vs2 = 3'(b); scalar = sc;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        if (lat > 1) check(busy == 1'b1, "R9", "busy after issue", 64'(busy), 64'd1);
        while (!done && cyc < 300) begin
            if (intrude && cyc == 3) begin
                // R11: second request during an active operation
                start = 1'b1; op = 3'd5; scalar = 32'd3;
            end
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        check(cyc == lat, "R9", "latency to done", 64'(cyc), 64'(lat));
        model(o, m, d, a, b, sc);
        @(negedge clk);
        check(vlen == 7'(exp_vl), intrude ? "R11" : req, "length", 64'(vlen), 64'(exp_vl));
        check(mask == exp_mask, req, "mask", mask, exp_mask);
        for (int r = 0; r < 8; r++) begin
            int bad;
            bad = -1;
            for (int i = 63; i >= 0; i--)
                if (rf[r][i] !== exp_rf[r][i]) bad = i;
            if (bad >= 0)
                check(1'b0, req, $sformatf("reg %0d elem %0d", r, bad),
                      64'(rf[r][bad]), 64'(exp_rf[r][bad]));
            else
                checks++;
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int r = 0; r < 8; r++)
            for (int i = 0; i < 64; i++)
                exp_rf[r][i] = (r < 4) ? 32'($urandom % 4) : $urandom;
        exp_mask = '0;
        exp_vl   = 64;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(vlen == 7'd64, "R1", "reset length", 64'(vlen), 64'd64);
        check(mask == 64'd0, "R1", "reset mask", mask, 64'd0);
        check(!busy && !done, "R1", "reset busy/done", 64'({busy, done}), 64'd0);

        issue(5, 0, 0, 0, 0, 32'd100, "R2", 0);          // saturates
        issue(0, 0, 5, 0, 1, 0, "R4", 0);                 // full add
        issue(2, 0, 6, 2, 3, 0, "R6", 0);                 // full multiply
        issue(5, 0, 0, 0, 0, 32'd20, "R2", 0);
        issue(4, 1, 0, 0, 1, 0, "R7", 0);                 // partial compare
        issue(1, 1, 7, 0, 2, 32'h1234_5678, "R8", 0);     // masked scalar add
        issue(3, 1, 2, 0, 2, 32'd7, "R8", 0);             // masked, vd aliases src
        issue(6, 0, 1, 0, 0, 32'hA5A5_0F0F, "R3", 0);     // high word
        issue(6, 0, 0, 0, 0, 32'h0000_FFFF, "R3", 0);     // low word
        issue(5, 0, 0, 0, 0, 32'd64, "R2", 0);
        issue(0, 1, 4, 4, 5, 0, "R8", 0);                 // masked, wide range
        issue(5, 0, 0, 0, 0, 32'd0, "R2", 0);
        issue(0, 0, 5, 6, 7, 0, "R10", 0);                // zero length add
        issue(4, 0, 0, 1, 2, 0, "R10", 0);                // zero length compare
        issue(7, 0, 0, 0, 0, 0, "R12", 0);
        issue(5, 0, 0, 0, 0, 32'd40, "R2", 0);
        issue(2, 0, 3, 3, 4, 0, "R11", 1);                // intrusion during busy
        for (int n = 0; n < 60; n++) begin
            int o;
            o = int'($urandom % 8);
            if (o == 5 && ($urandom % 2) == 0)
                issue(o, 0, 0, 0, 0, 32'($urandom % 72), req_of(o), 0);
            else
                issue(o, 1'($urandom), int'($urandom % 8), int'($urandom % 8),
                      int'($urandom % 8), $urandom, req_of(o), 0);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule